// File: doc/BRIEF.md
# Dual-Loop Digital Clock Recovery

This block recovers a clock from a stream of reference edges using only a free-running local oscillator and counters. A variable divider counts oscillator cycles and emits one enable pulse per recovered period. Each rising reference edge is classified by where it falls against the midpoint of the divider count. Edges that fall before the midpoint shorten the current period by one count. Edges that fall after it lengthen the period by one count.

A slow outer loop watches those per-edge corrections over a fixed window of edges. When the window's net correction leans past a threshold, the outer loop moves the nominal divisor one step toward the reference. The divisor is kept within ±1/16 of its design value, which is a pull-in span of 6.25%. The fast inner loop only ever nudges single periods, so the recovered clock does not jitter by more than one count, whatever the divisor is doing. A lock flag reports that the nominal divisor has held still for a run of windows. With the default parameters it suits a 1.544 Mbit/s line clocked from a 64× oscillator.

Top module: `dual_loop_cdr`

## Requirements
- R1: During and straight after reset, `rclk_en` is 0, `locked` is 0 and `nom_div` equals DIV_NOM.
- R2: With no reference edge, `rclk_en` is a one-cycle pulse that repeats every `nom_div` oscillator cycles.
- R3: A rising reference edge sampled while the divider count is below `nom_div`/2 (integer halving) is early. It shortens the period in progress by one cycle.
- R4: A rising reference edge sampled while the count is above `nom_div`/2 is late. It lengthens the period in progress by one cycle.
- R5: A rising reference edge sampled at a count equal to `nom_div`/2 is on time. It leaves the period length unchanged.
- R6: Only a 0-to-1 transition of `ref_in` is an edge. Holding `ref_in` high makes no further correction.
- R7: Every WIN_EDGES-th edge closes a window. A net correction in the window (early −1, late +1) above STEP_TH raises `nom_div` by one. A net below −STEP_TH lowers it by one. Any other net leaves it unchanged. `nom_div` changes at no other time.
- R8: `nom_div` never leaves the range DIV_NOM − DIV_NOM/16 to DIV_NOM + DIV_NOM/16. A step beyond a bound is dropped.
- R9: `locked` rises at the close of the LOCK_WINDOWS-th consecutive window without a divisor change. It falls at the close of any window that changes the divisor.
- R10: A late edge sampled in the last cycle of a period lengthens the following period, which then lasts `nom_div`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference signal whose rising edges are tracked |
| rclk_en | output | 1 | One-cycle pulse per recovered clock period |
| locked | output | 1 | Nominal divisor has been stable for the lock run |
| nom_div | output | DW | Current nominal division number |

## Verification
The bench builds the block with a nominal divisor of 32, which gives a divisor range of 30 to 34. It uses a window of 8 edges, a threshold of zero and a lock run of 4 windows. With these values, reference periods of 35 and 29 cycles drive the divisor into each bound, to clamp and then lock, within a few hundred edges. The small window also lets a hand-placed series of early, late, on-time and wrap-cycle edges close one whole window with a zero net, which shows that such a window leaves the divisor unchanged.

// File: rtl/dlr_pkg.sv
`timescale 1ns/1ps
package dlr_pkg;
    // Phase decision for one reference edge against the divider midpoint
    typedef enum logic [1:0] {
        PH_NONE  = 2'd0,
        PH_EARLY = 2'd1,
        PH_LATE  = 2'd2
    } ph_e;
endpackage

// File: rtl/dlr_phase_det.sv
`timescale 1ns/1ps
module dlr_phase_det
    import dlr_pkg::*;
#(
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_in,
    input  logic [DW-1:0] cnt_i,
    input  logic [DW-1:0] nom_i,
    output logic          edge_o,
    output ph_e           ph_o
);
    typedef struct packed {
        logic prev;
    } pd_state_t;

    pd_state_t st_d, st_q;
    logic [DW-1:0] mid;

    always_comb begin
        st_d      = st_q;
        st_d.prev = ref_in;
        mid       = nom_i >> 1;
        edge_o    = ref_in & ~st_q.prev;
        ph_o      = PH_NONE;
        if (edge_o) begin
            if (cnt_i < mid)      ph_o = PH_EARLY;
            else if (cnt_i > mid) ph_o = PH_LATE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

    // R6
    level_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ref_in) && ref_in) |-> (ph_o == PH_NONE));
endmodule

// File: rtl/dlr_divider.sv
`timescale 1ns/1ps
module dlr_divider
    import dlr_pkg::*;
#(
    parameter int DW      = 7,
    parameter int DIV_NOM = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] nom_i,
    input  ph_e           ph_i,
    output logic [DW-1:0] cnt_o,
    output logic          tick_o
);
    localparam logic [DW-1:0] ONE   = DW'(1);
    localparam logic [DW-1:0] START = DW'(DIV_NOM);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] per;
        logic          tick;
    } dv_state_t;

    dv_state_t st_d, st_q;
    logic          wrap;
    logic [DW-1:0] base;

    always_comb begin
        st_d      = st_q;
        wrap      = (st_q.cnt == st_q.per - ONE);
        base      = wrap ? nom_i : st_q.per;
        st_d.tick = wrap;
        st_d.cnt  = wrap ? '0 : st_q.cnt + ONE;
        unique case (ph_i)
            PH_EARLY: st_d.per = base - ONE;
            PH_LATE:  st_d.per = base + ONE;
            default:  st_d.per = base;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.per  <= START;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign tick_o = st_q.tick;

    // R3
    early_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_i == PH_EARLY) |=> (st_q.per == $past(st_q.per) - ONE));

    // R4
    late_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_i == PH_LATE && !wrap) |=> (st_q.per == $past(st_q.per) + ONE));

    // R10
    wrap_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_i == PH_LATE && wrap) |=> (st_q.per == $past(nom_i) + ONE && st_q.cnt == '0));

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |=> !st_q.tick);
endmodule

// File: rtl/dlr_freq_loop.sv
`timescale 1ns/1ps
module dlr_freq_loop
    import dlr_pkg::*;
#(
    parameter int DW        = 7,
    parameter int DIV_NOM   = 64,
    parameter int PULL_DEN  = 16,
    parameter int WIN       = 64,
    parameter int TH        = 4,
    parameter int LOCK_WIN  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_i,
    input  ph_e           ph_i,
    output logic [DW-1:0] nom_o,
    output logic          locked_o
);
    localparam int EW = $clog2(WIN);
    localparam int CW = $clog2(WIN + 1) + 1;
    localparam int SW = $clog2(LOCK_WIN + 1);
    localparam logic [DW-1:0] ONE    = DW'(1);
    localparam logic [DW-1:0] NOM_RS = DW'(DIV_NOM);
    localparam logic [DW-1:0] NOM_LO = DW'(DIV_NOM - DIV_NOM / PULL_DEN);
    localparam logic [DW-1:0] NOM_HI = DW'(DIV_NOM + DIV_NOM / PULL_DEN);
    localparam logic [EW-1:0] LAST_E = EW'(WIN - 1);
    localparam logic [SW-1:0] LOCK_N = SW'(LOCK_WIN);

    typedef struct packed {
        logic [DW-1:0]        nom;
        logic [EW-1:0]        edges;
        logic signed [CW-1:0] corr;
        logic [SW-1:0]        stable;
        logic                 locked;
    } fl_state_t;

    fl_state_t st_d, st_q;
    logic signed [CW-1:0] delta;
    logic signed [CW-1:0] net;
    logic                 win_end;
    logic [DW-1:0]        nom_next;

    always_comb begin
        st_d     = st_q;
        delta    = '0;
        if (ph_i == PH_EARLY)     delta = -CW'(1);
        else if (ph_i == PH_LATE) delta = CW'(1);
        net      = st_q.corr + delta;
        win_end  = edge_i && (st_q.edges == LAST_E);
        nom_next = st_q.nom;
        if (int'(net) > TH && st_q.nom < NOM_HI)       nom_next = st_q.nom + ONE;
        else if (int'(net) < -TH && st_q.nom > NOM_LO) nom_next = st_q.nom - ONE;

        if (win_end) begin
            st_d.edges = '0;
            st_d.corr  = '0;
            st_d.nom   = nom_next;
            if (nom_next != st_q.nom) begin
                st_d.stable = '0;
                st_d.locked = 1'b0;
            end else begin
                if (st_q.stable != LOCK_N) st_d.stable = st_q.stable + SW'(1);
                st_d.locked = st_q.locked | (st_d.stable == LOCK_N);
            end
        end else if (edge_i) begin
            st_d.edges = st_q.edges + EW'(1);
            st_d.corr  = net;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.nom    <= NOM_RS;
            st_q.edges  <= '0;
            st_q.corr   <= '0;
            st_q.stable <= '0;
            st_q.locked <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nom_o    = st_q.nom;
    assign locked_o = st_q.locked;

    // R8
    nom_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.nom >= NOM_LO && st_q.nom <= NOM_HI));

    // R7
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.nom) |-> ($past(win_end) &&
            (st_q.nom == $past(st_q.nom) + ONE || st_q.nom == $past(st_q.nom) - ONE)));

    // R9
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.nom) |-> !st_q.locked);

    // R9
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.locked) |-> ($past(win_end) && $stable(st_q.nom)));
endmodule

// File: rtl/dual_loop_cdr.sv
`timescale 1ns/1ps
module dual_loop_cdr
    import dlr_pkg::*;
#(
    parameter int DIV_NOM      = 64,
    parameter int PULL_DEN     = 16,
    parameter int WIN_EDGES    = 64,
    parameter int STEP_TH      = 4,
    parameter int LOCK_WINDOWS = 16,
    localparam int DW = $clog2(DIV_NOM + DIV_NOM / PULL_DEN + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_in,
    output logic          rclk_en,
    output logic          locked,
    output logic [DW-1:0] nom_div
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] nom;
    logic          edge_seen;
    ph_e           ph;

    dlr_phase_det #(.DW(DW)) u_pd (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .cnt_i  (cnt),
        .nom_i  (nom),
        .edge_o (edge_seen),
        .ph_o   (ph)
    );

    dlr_divider #(.DW(DW), .DIV_NOM(DIV_NOM)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .nom_i  (nom),
        .ph_i   (ph),
        .cnt_o  (cnt),
        .tick_o (rclk_en)
    );

    dlr_freq_loop #(
        .DW       (DW),
        .DIV_NOM  (DIV_NOM),
        .PULL_DEN (PULL_DEN),
        .WIN      (WIN_EDGES),
        .TH       (STEP_TH),
        .LOCK_WIN (LOCK_WINDOWS)
    ) u_fl (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (edge_seen),
        .ph_i     (ph),
        .nom_o    (nom),
        .locked_o (locked)
    );

    assign nom_div = nom;
endmodule

// File: tb/dual_loop_cdr_test.sv
`timescale 1ns/1ps
module dual_loop_cdr_test;
    localparam int NOM  = 32;
    localparam int WIN  = 8;
    localparam int TH   = 0;
    localparam int LKW  = 4;
    localparam int NMIN = NOM - NOM / 16;
    localparam int NMAX = NOM + NOM / 16;
    localparam int DW   = $clog2(NOM + NOM / 16 + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic rclk_en;
    logic locked;
    logic [DW-1:0] nom_div;

    int n_chk = 0;
    int n_fail = 0;
    bit running = 0;
    bit done = 0;
    int max_nom = 0;
    int min_nom = 1000;
    bit saw_unlock = 0;

    always #2.5 clk = ~clk;

    dual_loop_cdr #(
        .DIV_NOM(NOM), .PULL_DEN(16), .WIN_EDGES(WIN),
        .STEP_TH(TH), .LOCK_WINDOWS(LKW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
        .rclk_en(rclk_en), .locked(locked), .nom_div(nom_div)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    int  m_cnt, m_per, m_nom, m_corr, m_edges, m_stable;
    bit  m_locked, m_tick, m_prev;

    always @(posedge clk) begin
        int d, nn, sum;
        bit e, wrap;
        if (!rst_n) begin
            m_cnt = 0; m_per = NOM; m_nom = NOM; m_corr = 0; m_edges = 0;
            m_stable = 0; m_locked = 0; m_tick = 0; m_prev = 0;
        end else begin
            d = 0;
            e = ref_in && !m_prev;
            if (e) d = (m_cnt < m_nom / 2) ? -1 : ((m_cnt > m_nom / 2) ? 1 : 0);
            wrap = (m_cnt == m_per - 1);
            m_per = (wrap ? m_nom : m_per) + d;
            m_cnt = wrap ? 0 : m_cnt + 1;
            m_tick = wrap;
            m_prev = ref_in;
            if (e) begin
                if (m_edges == WIN - 1) begin
                    sum = m_corr + d;
                    nn = m_nom;
                    if (sum > TH && nn < NMAX) nn = nn + 1;
                    else if (sum < -TH && nn > NMIN) nn = nn - 1;
                    if (nn != m_nom) begin
                        m_stable = 0; m_locked = 0;
                    end else begin
                        if (m_stable < LKW) m_stable++;
                        if (m_stable == LKW) m_locked = 1;
                    end
                    m_nom = nn; m_corr = 0; m_edges = 0;
                end else begin
                    m_corr += d; m_edges++;
                end
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && running) begin
            chk(rclk_en == m_tick, "R2 rclk_en vs model", int'(rclk_en), int'(m_tick));
            chk(int'(nom_div) == m_nom, "R7 nom_div vs model", int'(nom_div), m_nom);
            chk(locked == m_locked, "R9 locked vs model", int'(locked), int'(m_locked));
            if (int'(nom_div) > max_nom) max_nom = int'(nom_div);
            if (int'(nom_div) < min_nom) min_nom = int'(nom_div);
            if (!locked) saw_unlock = 1;
        end
    end

    task automatic wait_tick();
        do @(negedge clk); while (!rclk_en);
    endtask

    task automatic gap(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!rclk_en);
    endtask

    // raise ref_in so its edge is sampled at divider count k
    task automatic edge_at(input int k, output int len);
        wait_tick();
        len = 0;
        do begin
            @(negedge clk);
            len++;
            if (len == k) ref_in = 1'b1;
        end while (!rclk_en);
    endtask

    task automatic drive_ref(input int per, input int count);
        for (int i = 0; i < count; i++) begin
            ref_in = 1'b1;
            repeat (3) @(negedge clk);
            ref_in = 1'b0;
            repeat (per - 3) @(negedge clk);
        end
    endtask

    initial begin
        int l;
        repeat (4) @(negedge clk);
        // R1 reset values
        chk(rclk_en == 1'b0, "R1 rclk_en in reset", int'(rclk_en), 0);
        chk(locked == 1'b0, "R1 locked in reset", int'(locked), 0);
        chk(int'(nom_div) == NOM, "R1 nom_div in reset", int'(nom_div), NOM);
        rst_n = 1'b1;
        running = 1;
        @(negedge clk);
        chk(locked == 1'b0 && rclk_en == 1'b0, "R1 after release", int'(locked), 0);

        // R2 free-running period
        wait_tick();
        gap(l); chk(l == NOM, "R2 period", l, NOM);
        gap(l); chk(l == NOM, "R2 period", l, NOM);

        edge_at(5, l);  chk(l == NOM - 1, "R3 early edge", l, NOM - 1);
        ref_in = 1'b0;
        edge_at(20, l); chk(l == NOM + 1, "R4 late edge", l, NOM + 1);
        ref_in = 1'b0;
        edge_at(16, l); chk(l == NOM, "R5 on-time edge", l, NOM);
        gap(l);         chk(l == NOM, "R6 held level", l, NOM);
        ref_in = 1'b0;
        edge_at(31, l); chk(l == NOM, "R10 wrap edge current", l, NOM);
        ref_in = 1'b0;
        gap(l);         chk(l == NOM + 1, "R10 wrap edge next", l, NOM + 1);
        edge_at(5, l);  chk(l == NOM - 1, "R3 early edge again", l, NOM - 1);
        ref_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            edge_at(16, l);
            ref_in = 1'b0;
        end
        chk(int'(nom_div) == NOM, "R7 zero-net window", int'(nom_div), NOM);

        // slow reference: pull to the upper bound and lock
        drive_ref(35, 500);
        chk(int'(nom_div) == NMAX, "R8 upper bound reached", int'(nom_div), NMAX);
        chk(max_nom <= NMAX, "R8 never above bound", max_nom, NMAX);
        chk(locked == 1'b1, "R9 locked at bound", int'(locked), 1);

        // fast reference: pull down, unlock, relock
        saw_unlock = 0;
        drive_ref(29, 500);
        chk(saw_unlock, "R9 cleared on change", int'(saw_unlock), 1);
        chk(int'(nom_div) == NMIN, "R7 stepped down to bound", int'(nom_div), NMIN);
        chk(min_nom >= NMIN, "R8 never below bound", min_nom, NMIN);
        chk(locked == 1'b1, "R9 relocked", int'(locked), 1);

        running = 0;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule